// File: doc/BRIEF.md
# Remote Terminal Status and Discrete Logic

This block keeps the status and discrete-signal state of a serial data-bus remote terminal. It runs on a 16 MHz clock. A separate word decoder and encoder sends it single-cycle pulses: a command word arrived (with the address it carries), a message started, a message was valid, a message ended, a word or format error was seen, transmission finished, and a loopback compare result with a pass/fail flag. Strap inputs give the terminal's own address and a broadcast-enable setting. A configuration bit and two active-low inputs ask for the subsystem flag and the terminal flag.

From these inputs the block produces four active-low discretes: in-command, message-error, broadcast-received and terminal-fail. It also assembles a 16-bit status word that the transmit path sends back to the bus controller. Broadcast indication appears after a fixed delay and is held. Loopback and timeout failures are latched and then re-evaluated on each valid addressed message.

Top module: `rt_status_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `incmd_n`, `msgerr_n`, `bcast_n` and `rtfail_n` are all 1.
- R2: A `cmd_rx` pulse whose address is for this terminal (its own address, or the broadcast address) drives `incmd_n` to 0 in the next cycle. It stays 0 until the cycle after a `msg_end` pulse. A command for any other address leaves `incmd_n` unchanged.
- R3: A `word_err` pulse drives `msgerr_n` to 0 in the next cycle. A `msg_start` pulse returns it to 1. When both arrive in the same cycle, `msgerr_n` becomes 0.
- R4: Address 31 is the broadcast address only while `bcast_en` is 1. While `bcast_en` is 0, a command to address 31 is a normal addressed command when `own_addr` is 31, and it never raises the broadcast indication.
- R5: After a broadcast command is sampled, `bcast_n` falls exactly BCAST_DELAY clocks later (default 30, which lies inside the 22 to 36 clock window). It stays 0 until a command to the terminal's own address arrives. That command also cancels a broadcast indication that is still pending. A command to another address does not clear it.
- R6: A `lb_result` pulse with `lb_ok` = 0 drives `rtfail_n` to 0 in the next cycle.
- R7: If TIMEOUT_CLKS clocks (default 12288, which is 768 us) pass after a `tx_done` pulse with no `lb_result`, `rtfail_n` falls at that moment. A `lb_result` that arrives before then cancels the timeout.
- R8: When a valid message that is not a broadcast ends, `rtfail_n` is set to 0 if a failure occurred since that message's `msg_start`, and to 1 otherwise. A valid broadcast message leaves `rtfail_n` unchanged.
- R9: Status bit 2 is 1 when `ssf_n` is 0 or `cfg_ssf` is 1.
- R10: Status bit 0 is 1 when `rtf_n` is 0.
- R11: Status bits 15:11 equal `own_addr`, bit 10 equals the inverse of `msgerr_n`, and bit 4 equals the inverse of `bcast_n`. Bits 9:5, 3 and 1 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz clock |
| rst_n | input | 1 | Active-low reset |
| cmd_rx | input | 1 | Command word received pulse |
| cmd_addr | input | 5 | Address field of the received command |
| msg_start | input | 1 | Message start pulse |
| msg_valid | input | 1 | Message completed valid pulse |
| msg_end | input | 1 | Message sequence finished pulse |
| word_err | input | 1 | Word or format error pulse |
| tx_done | input | 1 | End of transmission pulse, starts the timeout |
| lb_result | input | 1 | Loopback compare result pulse |
| lb_ok | input | 1 | Loopback compare passed, qualified by lb_result |
| bcast_en | input | 1 | Strap: address 31 is the broadcast address |
| own_addr | input | 5 | Strap: this terminal's address |
| cfg_ssf | input | 1 | Configuration request for the subsystem flag |
| ssf_n | input | 1 | Active-low subsystem flag request |
| rtf_n | input | 1 | Active-low terminal flag request |
| status_word | output | 16 | Assembled status word |
| incmd_n | output | 1 | Active-low in-command discrete |
| msgerr_n | output | 1 | Active-low message-error discrete |
| bcast_n | output | 1 | Active-low broadcast-received discrete |
| rtfail_n | output | 1 | Active-low terminal-fail discrete |

## Verification
The properties assume that each event input is a single-cycle pulse, that at most one command arrives per cycle, and that the straps `own_addr` and `bcast_en` stay still while a message is in progress. The bench changes straps only between messages. It raises each event for exactly one cycle from a task, and it combines pulses in the same cycle only where a requirement defines a priority, namely an error together with a message start. Timeout and broadcast-delay checks count clocks from the sampled pulse. They sample one cycle before and at the expected edge.

// File: rtl/rt_status_unit.sv
module rt_status_unit #(
  parameter int BCAST_DELAY  = 30,
  parameter int TIMEOUT_CLKS = 12288
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_rx,
  input  logic [4:0]  cmd_addr,
  input  logic        msg_start,
  input  logic        msg_valid,
  input  logic        msg_end,
  input  logic        word_err,
  input  logic        tx_done,
  input  logic        lb_result,
  input  logic        lb_ok,
  input  logic        bcast_en,
  input  logic [4:0]  own_addr,
  input  logic        cfg_ssf,
  input  logic        ssf_n,
  input  logic        rtf_n,
  output logic [15:0] status_word,
  output logic        incmd_n,
  output logic        msgerr_n,
  output logic        bcast_n,
  output logic        rtfail_n
);
  localparam logic [4:0] BCAST_ADDR = 5'h1f;
  localparam int BW = $clog2(BCAST_DELAY + 1);
  localparam int TW = $clog2(TIMEOUT_CLKS + 1);

  logic [BW-1:0] bc_cnt;
  logic [TW-1:0] tmo_cnt;
  logic          cur_bcast;
  logic          fail_seen;

  wire is_bc_addr = bcast_en && (cmd_addr == BCAST_ADDR);
  wire own_cmd    = cmd_rx && !is_bc_addr && (cmd_addr == own_addr);
  wire bc_cmd     = cmd_rx && is_bc_addr;
  wire tmo_fire   = (tmo_cnt == TW'(1)) && !lb_result;
  wire fail_evt   = (lb_result && !lb_ok) || tmo_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      incmd_n   <= 1'b1;
      cur_bcast <= 1'b0;
    end else if (own_cmd || bc_cmd) begin
      incmd_n   <= 1'b0;
      cur_bcast <= bc_cmd;
    end else if (msg_end) begin
      incmd_n   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         msgerr_n <= 1'b1;
    else if (word_err)  msgerr_n <= 1'b0;
    else if (msg_start) msgerr_n <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_cnt  <= '0;
      bcast_n <= 1'b1;
    end else if (own_cmd) begin
      bc_cnt  <= '0;
      bcast_n <= 1'b1;
    end else begin
      if (bc_cmd)              bc_cnt <= BW'(BCAST_DELAY);
      else if (bc_cnt != '0)   bc_cnt <= bc_cnt - 1'b1;
      if (bc_cnt == BW'(1))    bcast_n <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              tmo_cnt <= '0;
    else if (lb_result)      tmo_cnt <= '0;
    else if (tx_done)        tmo_cnt <= TW'(TIMEOUT_CLKS);
    else if (tmo_cnt != '0)  tmo_cnt <= tmo_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_seen <= 1'b0;
      rtfail_n  <= 1'b1;
    end else begin
      if (msg_start)     fail_seen <= fail_evt;
      else if (fail_evt) fail_seen <= 1'b1;
      if (fail_evt)                     rtfail_n <= 1'b0;
      else if (msg_valid && !cur_bcast) rtfail_n <= !fail_seen;
    end
  end

  assign status_word = {own_addr, !msgerr_n, 5'b0, !bcast_n, 1'b0,
                        (!ssf_n || cfg_ssf), 1'b0, !rtf_n};
endmodule

module rt_status_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_rx,
  input logic [4:0] cmd_addr,
  input logic       msg_start,
  input logic       word_err,
  input logic       lb_result,
  input logic       lb_ok,
  input logic       bcast_en,
  input logic [4:0] own_addr,
  input logic       incmd_n,
  input logic       msgerr_n,
  input logic       bcast_n,
  input logic       rtfail_n
);
  logic own_c;
  assign own_c = cmd_rx && (cmd_addr == own_addr) && !(bcast_en && cmd_addr == 5'h1f);

  AST_INCMD_FALL: assert property (@(posedge clk) disable iff (!rst_n) own_c |=> !incmd_n); // R2
  AST_ERR_LOW: assert property (@(posedge clk) disable iff (!rst_n) word_err |=> !msgerr_n); // R3
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (msg_start && !word_err) |=> msgerr_n); // R3
  AST_BCAST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!bcast_n && !own_c) |=> !bcast_n); // R5
  AST_BCAST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) own_c |=> bcast_n); // R5
  AST_LB_FAIL: assert property (@(posedge clk) disable iff (!rst_n) (lb_result && !lb_ok) |=> !rtfail_n); // R6
endmodule

bind rt_status_unit rt_status_unit_chk u_chk (.*);

// File: tb/rt_status_unit_test.sv
module rt_status_unit_test;
  localparam int D = 30;
  localparam int T = 12288;

  logic clk = 0, rst_n = 0;
  logic cmd_rx = 0, msg_start = 0, msg_valid = 0, msg_end = 0, word_err = 0;
  logic tx_done = 0, lb_result = 0, lb_ok = 0, bcast_en = 0, cfg_ssf = 0;
  logic ssf_n = 1, rtf_n = 1;
  logic [4:0] cmd_addr = 0, own_addr = 0;
  logic [15:0] status_word;
  logic incmd_n, msgerr_n, bcast_n, rtfail_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rt_status_unit uut (.*);

  // {own_addr, ssf_n, cfg_ssf, rtf_n, expected status}
  localparam logic [23:0] VEC [6] = '{
    {5'h15, 3'b101, 16'hA800},
    {5'h00, 3'b001, 16'h0004},
    {5'h00, 3'b110, 16'h0005},
    {5'h1f, 3'b010, 16'hF805},
    {5'h01, 3'b111, 16'h0804},
    {5'h06, 3'b100, 16'h3001}
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(logic [4:0] a);
    @(negedge clk); cmd_rx = 1; cmd_addr = a;
    @(negedge clk); cmd_rx = 0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic lb(logic ok);
    @(negedge clk); lb_result = 1; lb_ok = ok;
    @(negedge clk); lb_result = 0; lb_ok = 0;
  endtask

  function automatic logic [15:0] disc();
    return {12'b0, incmd_n, msgerr_n, bcast_n, rtfail_n};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    tick(3);
    check("R1 discretes in reset", disc(), 16'h000f);
    rst_n = 1;
    tick(1);
    check("R1 discretes after reset", disc(), 16'h000f);

    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      {own_addr, ssf_n, cfg_ssf, rtf_n} = VEC[i][23:16];
      #1;
      check("R9 R10 R11 status vector", status_word, VEC[i][15:0]);
    end
    ssf_n = 1; cfg_ssf = 0; rtf_n = 1; own_addr = 5'd3; bcast_en = 1;

    cmd(5'd7);
    check("R2 other address ignored", {15'b0, incmd_n}, 16'h1);
    cmd(5'd3);
    check("R2 own command", {15'b0, incmd_n}, 16'h0);
    pulse(msg_end);
    check("R2 message end", {15'b0, incmd_n}, 16'h1);

    pulse(word_err);
    check("R3 error low", {15'b0, msgerr_n}, 16'h0);
    check("R11 bit10 set", status_word, 16'h1C00);
    pulse(msg_start);
    check("R3 start clears", {15'b0, msgerr_n}, 16'h1);
    @(negedge clk); msg_start = 1; word_err = 1;
    @(negedge clk); msg_start = 0; word_err = 0;
    check("R3 error wins", {15'b0, msgerr_n}, 16'h0);
    pulse(msg_start);

    cmd(5'd31);
    check("R4 broadcast sets in-command", {15'b0, incmd_n}, 16'h0);
    tick(D - 1);
    check("R5 not yet", {15'b0, bcast_n}, 16'h1);
    tick(1);
    check("R5 falls at delay", {15'b0, bcast_n}, 16'h0);
    check("R11 bit4 set", status_word, 16'h1810);
    cmd(5'd7);
    check("R5 other address holds", {15'b0, bcast_n}, 16'h0);
    cmd(5'd3);
    check("R5 own command clears", {15'b0, bcast_n}, 16'h1);
    cmd(5'd31);
    tick(5);
    cmd(5'd3);
    tick(D + 10);
    check("R5 pending cancelled", {15'b0, bcast_n}, 16'h1);
    pulse(msg_end);

    bcast_en = 0; own_addr = 5'd31;
    cmd(5'd31);
    check("R4 addr31 as own", {15'b0, incmd_n}, 16'h0);
    tick(D + 10);
    check("R4 no broadcast when disabled", {15'b0, bcast_n}, 16'h1);
    pulse(msg_end);
    bcast_en = 1; own_addr = 5'd3;

    cmd(5'd3); pulse(msg_start);
    lb(0);
    check("R6 loopback fail", {15'b0, rtfail_n}, 16'h0);
    pulse(msg_valid); pulse(msg_end);
    check("R8 failed message keeps low", {15'b0, rtfail_n}, 16'h0);
    cmd(5'd3); pulse(msg_start); pulse(msg_valid); pulse(msg_end);
    check("R8 clean message clears", {15'b0, rtfail_n}, 16'h1);
    lb(0);
    cmd(5'd31); pulse(msg_start); pulse(msg_valid); pulse(msg_end);
    check("R8 broadcast message no change", {15'b0, rtfail_n}, 16'h0);
    cmd(5'd3); pulse(msg_start); pulse(msg_valid); pulse(msg_end);
    check("R8 clean addressed clears", {15'b0, rtfail_n}, 16'h1);

    pulse(tx_done);
    tick(T - 1);
    check("R7 before timeout", {15'b0, rtfail_n}, 16'h1);
    tick(1);
    check("R7 timeout", {15'b0, rtfail_n}, 16'h0);
    cmd(5'd3); pulse(msg_start); pulse(msg_valid); pulse(msg_end);
    pulse(tx_done);
    tick(100);
    lb(1);
    tick(T);
    check("R7 loopback stops timer", {15'b0, rtfail_n}, 16'h1);

    cmd(5'd3); pulse(word_err); lb(0);
    @(negedge clk); rst_n = 0;
    tick(1);
    check("R1 reset clears discretes", disc(), 16'h000f);
    check("R1 R11 reset status", status_word, 16'h1800);
    rst_n = 1;
    tick(2);
    finish_run();
  end
endmodule